// File: doc/BRIEF.md
# Supply Reset Supervisor

This block turns digitized supply-monitor flags into a system reset. Two comparator flags describe the supervised rail. `railLow` means the rail is under the lower (falling) threshold. `railHigh` means it is over the upper (rising) threshold. A third input, `manualReq`, carries a pushbutton request. All three are assumed to be already synchronized to `clk`. The asynchronous `porN` input comes from the power-detect cell and forces the block into its power-on state.

From power-up the block holds `sysReset` high. It releases only after `railHigh` has been seen on a programmed number of consecutive clocks. Any loss of `railHigh` during that wait starts the count again. While running, a `railLow` episode that reaches the filter length, or a manual request, starts a reset pulse. The pulse has a fixed minimum length and is followed by a fresh stabilization wait. `rstCause` reports, one-hot, what started the most recent reset and keeps that value until a new cause arrives.

Top module: `supply_rst_top`

## Requirements
- R1: While `porN` is low, `sysReset` is 1 and `rstCause` is 3'b001 (power-on). This takes effect immediately, without waiting for a clock. `sysReset` is still 1 on the first clock after `porN` rises.
- R2: After power-on, `sysReset` falls on the STABLE_CYC-th consecutive rising edge at which `railHigh` is 1 while waiting. The first of these edges is the one following the edge that ended the power-on state.
- R3: A clock with `railHigh` at 0 during the wait restarts the count. A full STABLE_CYC run is then needed again.
- R4: With both flags at 0 (the rail between the thresholds), a waiting block keeps `sysReset` at 1 and a running block keeps it at 0.
- R5: While running, `railLow` on FILTER_CYC consecutive edges raises `sysReset` on the last of them. A shorter run is ignored and `sysReset` stays 0.
- R6: A reset started by brown-out or manual request lasts exactly PULSE_CYC+STABLE_CYC clocks when `railHigh` is 1 from the end of the pulse. This holds even if the cause disappears at once.
- R7: `manualReq` sampled while running starts a reset pulse. It wins over `railLow` sampled on the same edge. It is ignored while `sysReset` is 1.
- R8: `rstCause` is one-hot: bit0 power-on, bit1 brown-out, bit2 manual. It is written only when a reset starts and holds its value through that reset and the run that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Asynchronous power-on indication, active low |
| railLow | input | 1 | Rail under the lower threshold |
| railHigh | input | 1 | Rail over the upper threshold |
| manualReq | input | 1 | Pushbutton reset request |
| sysReset | output | 1 | System reset, active high |
| rstCause | output | 3 | One-hot cause of the last reset |

## Verification
`sysReset` is decoded from the state register. It therefore changes right after the edge that samples the deciding input:
- Release comes on the STABLE_CYC-th qualifying edge.
- A brown-out reset comes on the FILTER_CYC-th low edge.
- A manual reset comes on the edge that samples the request.

After a brown-out or manual start, release follows PULSE_CYC+STABLE_CYC edges after the starting edge. The bench drives inputs and samples outputs on falling edges. It counts whole clocks from the starting edge and compares against these sums, sweeping dip lengths on both sides of the filter and the stabilization limits.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;

  typedef enum logic [2:0] {
    PWR_HOLD   = 3'd0,
    RAIL_WAIT  = 3'd1,
    RUNNING    = 3'd2,
    DIP_FILTER = 3'd3,
    RST_PULSE  = 3'd4
  } supState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic setBrown;
    logic setManual;
  } supStrobe_t;

  localparam logic [2:0] CAUSE_POWER  = 3'b001;
  localparam logic [2:0] CAUSE_BROWN  = 3'b010;
  localparam logic [2:0] CAUSE_MANUAL = 3'b100;

endpackage

// File: rtl/supply_rst_datapath.sv
module supply_rst_datapath
  import supply_rst_pkg::*;
#(
  parameter int STABLE_CYC = 4096,
  parameter int FILTER_CYC = 1000,
  parameter int PULSE_CYC  = 200
) (
  input  logic       clk,
  input  logic       porN,
  input  supStrobe_t strobe,
  output logic       stableHit,
  output logic       filterHit,
  output logic       pulseHit,
  output logic [2:0] rstCause
);

  localparam int MAX_A = (STABLE_CYC > FILTER_CYC) ? STABLE_CYC : FILTER_CYC;
  localparam int MAX_CYC = (MAX_A > PULSE_CYC) ? MAX_A : PULSE_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntBase;

  assign cntBase = strobe.cntClr ? '0 : cnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cnt <= '0;
    end else begin
      cnt <= cntBase + CNT_W'(strobe.cntInc);
    end
  end

  assign stableHit = (cnt == CNT_W'(STABLE_CYC - 1));
  assign filterHit = (cnt == CNT_W'(FILTER_CYC - 1));
  assign pulseHit  = (cnt == CNT_W'(PULSE_CYC - 1));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rstCause <= CAUSE_POWER;
    end else if (strobe.setManual) begin
      rstCause <= CAUSE_MANUAL;
    end else if (strobe.setBrown) begin
      rstCause <= CAUSE_BROWN;
    end
  end

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!porN)
    $onehot(rstCause)); // R8
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!porN)
    !(strobe.setManual || strobe.setBrown) |=> $stable(rstCause)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!porN)
    cnt <= CNT_W'(MAX_CYC)); // R6

endmodule

// File: rtl/supply_rst_ctrl.sv
module supply_rst_ctrl
  import supply_rst_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       railLow,
  input  logic       railHigh,
  input  logic       manualReq,
  input  logic       stableHit,
  input  logic       filterHit,
  input  logic       pulseHit,
  output supStrobe_t strobe,
  output logic       rstOut
);

  supState_t state, stateNext;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= PWR_HOLD;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      PWR_HOLD: begin
        stateNext     = RAIL_WAIT;
        strobe.cntClr = 1'b1;
      end
      RAIL_WAIT: begin
        if (!railHigh) begin
          strobe.cntClr = 1'b1;
        end else if (stableHit) begin
          stateNext     = RUNNING;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      RUNNING: begin
        if (manualReq) begin
          stateNext        = RST_PULSE;
          strobe.cntClr    = 1'b1;
          strobe.setManual = 1'b1;
        end else if (railLow) begin
          stateNext     = DIP_FILTER;
          strobe.cntClr = 1'b1;
          strobe.cntInc = 1'b1;
        end
      end
      DIP_FILTER: begin
        if (manualReq) begin
          stateNext        = RST_PULSE;
          strobe.cntClr    = 1'b1;
          strobe.setManual = 1'b1;
        end else if (!railLow) begin
          stateNext     = RUNNING;
          strobe.cntClr = 1'b1;
        end else if (filterHit) begin
          stateNext       = RST_PULSE;
          strobe.cntClr   = 1'b1;
          strobe.setBrown = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      RST_PULSE: begin
        if (pulseHit) begin
          stateNext     = RAIL_WAIT;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: begin
        stateNext     = PWR_HOLD;
        strobe.cntClr = 1'b1;
      end
    endcase
  end

  assign rstOut = (state == PWR_HOLD) || (state == RAIL_WAIT) || (state == RST_PULSE);

  AST_RELEASE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!porN)
    $fell(rstOut) |-> $past(railHigh)); // R2
  AST_QUIET_RUN_STAYS: assert property (@(posedge clk) disable iff (!porN)
    (state == RUNNING && !railLow && !manualReq) |=> !rstOut); // R4
  AST_PULSE_EXIT: assert property (@(posedge clk) disable iff (!porN)
    (state == RST_PULSE) |=> (state == RST_PULSE || state == RAIL_WAIT)); // R6
  AST_RESET_IGNORES_MANUAL: assert property (@(posedge clk) disable iff (!porN)
    (rstOut && state != RAIL_WAIT) |=> rstOut); // R7

endmodule

// File: rtl/supply_rst_top.sv
module supply_rst_top
  import supply_rst_pkg::*;
#(
  parameter int STABLE_CYC = 4096,
  parameter int FILTER_CYC = 1000,
  parameter int PULSE_CYC  = 200
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       railLow,
  input  logic       railHigh,
  input  logic       manualReq,
  output logic       sysReset,
  output logic [2:0] rstCause
);

  supStrobe_t strobe;
  logic stableHit, filterHit, pulseHit;

  initial begin
    if (STABLE_CYC < 1 || PULSE_CYC < 1 || FILTER_CYC < 2)
      $error("supply_rst_top: cycle parameters out of range");
  end

  supply_rst_ctrl ctrl_i (
    .clk       (clk),
    .porN      (porN),
    .railLow   (railLow),
    .railHigh  (railHigh),
    .manualReq (manualReq),
    .stableHit (stableHit),
    .filterHit (filterHit),
    .pulseHit  (pulseHit),
    .strobe    (strobe),
    .rstOut    (sysReset)
  );

  supply_rst_datapath #(
    .STABLE_CYC (STABLE_CYC),
    .FILTER_CYC (FILTER_CYC),
    .PULSE_CYC  (PULSE_CYC)
  ) dp_i (
    .clk       (clk),
    .porN      (porN),
    .strobe    (strobe),
    .stableHit (stableHit),
    .filterHit (filterHit),
    .pulseHit  (pulseHit),
    .rstCause  (rstCause)
  );

endmodule

// File: tb/supply_rst_top_tb_top.sv
module supply_rst_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int S = 5;
  localparam int F = 3;
  localparam int P = 4;

  logic clk = 1'b0;
  logic porN, railLow, railHigh, manualReq;
  logic sysReset;
  logic [2:0] rstCause;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supply_rst_top #(.STABLE_CYC(S), .FILTER_CYC(F), .PULSE_CYC(P)) dut_i (
    .clk(clk), .porN(porN), .railLow(railLow), .railHigh(railHigh),
    .manualReq(manualReq), .sysReset(sysReset), .rstCause(rstCause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setRail(input logic lo, input logic hi);
    railLow = lo;
    railHigh = hi;
  endtask

  // counts clocks until sysReset falls
  task automatic waitRelease(output int n);
    n = 0;
    while (sysReset && n < 200) begin
      step();
      n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    bool_ok: begin end
    porN = 1'b0; manualReq = 1'b0; setRail(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 reset in por", sysReset, 1);
    chk("R1 cause in por", rstCause, 1);
    porN = 1'b1;
    step();
    chk("R1 first clock after por", sysReset, 1);

    // R3: runs of k high edges broken by a dip
    for (int k = 1; k < S; k++) begin
      setRail(1'b0, 1'b1);
      repeat (k) step();
      chk("R3 held during partial run", sysReset, 1);
      setRail(1'b1, 1'b0);
      step();
      chk("R3 held after dip", sysReset, 1);
    end
    // R4: between thresholds while waiting
    setRail(1'b0, 1'b0);
    repeat (2 * S) step();
    chk("R4 wait between thresholds", sysReset, 1);
    // R2: full run
    setRail(1'b0, 1'b1);
    repeat (S - 1) step();
    chk("R2 held at S-1", sysReset, 1);
    step();
    chk("R2 released at S", sysReset, 0);
    chk("R8 cause kept after por", rstCause, 1);

    // R4: between thresholds while running
    setRail(1'b0, 1'b0);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      n += sysReset;
    end
    chk("R4 run between thresholds", n, 0);
    setRail(1'b0, 1'b1);

    // R5/R6: sweep dip length
    for (int d = 1; d <= F + 2; d++) begin
      for (int i = 1; i <= d; i++) begin
        setRail(1'b1, 1'b0);
        step();
        chk("R5 dip response", sysReset, (i >= F) ? 1 : 0);
      end
      setRail(1'b0, 1'b1);
      if (d < F) begin
        step();
        chk("R5 short dip ignored", sysReset, 0);
        chk("R8 cause unchanged by short dip", rstCause, 1);
      end else begin
        chk("R8 brown-out cause", rstCause, 2);
        waitRelease(n);
        chk("R6 brown-out release time", n, P + S - (d - F));
        chk("R8 cause kept after brown-out", rstCause, 2);
      end
    end

    // R7/R6: one-clock manual request
    manualReq = 1'b1; step(); manualReq = 1'b0;
    chk("R7 manual asserts", sysReset, 1);
    chk("R8 manual cause", rstCause, 4);
    waitRelease(n);
    chk("R6 manual pulse width", n, P + S);

    // R7: manual ignored during brown-out reset
    setRail(1'b1, 1'b0);
    repeat (F) step();
    setRail(1'b0, 1'b1);
    manualReq = 1'b1; step(); manualReq = 1'b0;
    chk("R7 manual ignored in reset", rstCause, 2);
    waitRelease(n);
    chk("R7 release unchanged by manual", n, P + S - 1);

    // R7: priority over railLow on the same edge in run
    setRail(1'b1, 1'b0); manualReq = 1'b1; step(); manualReq = 1'b0;
    setRail(1'b0, 1'b1);
    chk("R7 priority in run", rstCause, 4);
    waitRelease(n);
    chk("R7 priority release", n, P + S);

    // R7: manual during filtering
    setRail(1'b1, 1'b0);
    repeat (F - 1) step();
    chk("R5 filtering no reset", sysReset, 0);
    manualReq = 1'b1; step(); manualReq = 1'b0;
    chk("R7 manual in filter", rstCause, 4);
    setRail(1'b0, 1'b1);
    waitRelease(n);
    chk("R7 filter manual release", n, P + S);

    // R1: asynchronous power-on while running
    #1 porN = 1'b0;
    #1;
    chk("R1 async reset", sysReset, 1);
    chk("R1 async cause", rstCause, 1);
    @(negedge clk);
    porN = 1'b1;
    step();
    chk("R1 held after por", sysReset, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule